// File: doc/BRIEF.md
# Text-Mode Character Display Engine

This block turns a screen of 8-bit character codes into a monochrome raster for a 640x480, 60 Hz monitor, using a 25 MHz pixel clock. The character buffer and the glyph bitmaps live in two external synchronous memories. The block drives an address into each memory and takes one byte back from each. The character grid is 80 columns by 40 rows. Each glyph cell is 8 pixels wide and 12 scanlines tall, and there is no per-character colour storage.

Fetches run two character cells ahead of the beam. The text address for a cell is held for six clocks before its code is captured. The code then forms a font address, which is also held for six clocks before the glyph byte is captured. The byte is shifted out one pixel per clock. Sync and blanking go through a delay line whose length matches this fetch pipeline, so the leftmost column lands exactly on the first visible pixel. Because every address is held this long, the memories can keep their enables tied active. Cursor overlay and colour selection are left to logic downstream of the 1-bit pixel output.

Top module: `txt_disp_engine`

## Requirements
- R1: Each line is 800 clocks long. At the ports, hsync is low (active) for exactly 96 clocks, from visible-line position 656 to 751 inclusive, where position 0 is the first visible pixel.
- R2: Each frame is 525 lines. vsync is low (active) on lines 490 and 491 only, and changes only at a line start, while hsync is high.
- R3: The pixel output is 0 at every position outside the 640x480 visible area.
- R4: The text address is row-major: cell (column c, row r) is at r*80+c. Cell (0,0) is at 0 and cell (79,39) is at 3199, and no address above 3199 is driven.
- R5: The font address is code*12 + s, where s (0 to 11) is the scanline within the cell. The highest address, 3071 for code 255, fits in 12 bits.
- R6: Glyph bits are shown MSB first: bit 7 of a font byte is the leftmost pixel of the cell.
- R7: Each text address and each font address is held unchanged for at least six clocks before the data returned for it is used.
- R8: Visible pixel x shows column x/8 with no horizontal offset, so pixel 0 of a line is bit 7 of column 0's glyph. Sync and pixel outputs share one pipeline delay.
- R9: Reset is asynchronous and active high. While it is asserted, hsync and vsync are 1, pixel is 0, and both address buses are 0.
- R10: Visible line y shows text row y/12 using scanline y mod 12 of each glyph.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock (25 MHz at default timing) |
| rst | input | 1 | Asynchronous reset, active high |
| textAddr | output | 12 | Character buffer address |
| textData | input | 8 | Character code from the buffer, one clock after the address |
| fontAddr | output | 12 | Glyph memory address |
| fontData | input | 8 | Glyph scanline byte, one clock after the address |
| pixel | output | 1 | Monochrome pixel, 0 outside the visible area |
| hsync | output | 1 | Horizontal sync, active low |
| vsync | output | 1 | Vertical sync, active low |

## Verification
The bench keeps the 8x12 cell but shrinks the raster to 64 visible pixels and 36 visible lines, with short porches and syncs. That gives a grid of 8 columns by 3 rows and a frame of 88 by 43 clocks. At this size several whole frames fit in the run. This brings within reach the frame wrap, the vsync pulse, every row advance, the last buffer address and a mid-frame asynchronous reset. The bench memories return inverted data whenever an address has been held for fewer than six clocks. Any fetch taken too early therefore shows up as a wrong pixel.

// File: rtl/txt_disp_pkg.sv
`timescale 1ns/1ps
package txt_disp_pkg;
  localparam int ADDR_W = 12;
  localparam int SCAN_W = 4;

  typedef struct packed {
    logic              loadText;
    logic              loadCode;
    logic              loadFont;
    logic              loadShift;
    logic [ADDR_W-1:0] textIdx;
    logic [SCAN_W-1:0] scan;
  } fetchCtl_t;
endpackage

// File: rtl/disp_timing_ctl.sv
`timescale 1ns/1ps
module disp_timing_ctl
  import txt_disp_pkg::*;
#(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  parameter int CELL_W = 8,
  parameter int CELL_H = 12
) (
  input  logic      clk,
  input  logic      rst,
  output fetchCtl_t ctl,
  output logic      hsyncOut,
  output logic      vsyncOut,
  output logic      visOut
);
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int COLS  = H_VIS / CELL_W;
  localparam int ROWS  = V_VIS / CELL_H;
  localparam int HC_W  = $clog2(H_TOT);
  localparam int VC_W  = $clog2(V_TOT);
  localparam int PH_W  = $clog2(CELL_W);
  localparam int COL_W = $clog2(COLS + 1);
  localparam int LAT   = 2 * CELL_W;

  localparam logic [HC_W-1:0]   H_LAST   = HC_W'(H_TOT - 1);
  localparam logic [HC_W-1:0]   H_VIS_C  = HC_W'(H_VIS);
  localparam logic [HC_W-1:0]   HS_START = HC_W'(H_VIS + H_FP);
  localparam logic [HC_W-1:0]   HS_END   = HC_W'(H_VIS + H_FP + H_SYNC);
  localparam logic [HC_W-1:0]   FONT_1ST = HC_W'(CELL_W);
  localparam logic [HC_W-1:0]   SH_FIRST = HC_W'(2 * CELL_W - 1);
  localparam logic [HC_W-1:0]   SH_END   = HC_W'(H_VIS + CELL_W);
  localparam logic [HC_W-1:0]   HS_WIDTH = HC_W'(H_SYNC);
  localparam logic [VC_W-1:0]   V_LAST   = VC_W'(V_TOT - 1);
  localparam logic [VC_W-1:0]   V_VIS_C  = VC_W'(V_VIS);
  localparam logic [VC_W-1:0]   VS_START = VC_W'(V_VIS + V_FP);
  localparam logic [VC_W-1:0]   VS_END   = VC_W'(V_VIS + V_FP + V_SYNC);
  localparam logic [PH_W-1:0]   PH_LAST  = PH_W'(CELL_W - 1);
  localparam logic [SCAN_W-1:0] SC_LAST  = SCAN_W'(CELL_H - 1);
  localparam logic [ADDR_W-1:0] COLS_A   = ADDR_W'(COLS);
  localparam logic [ADDR_W-1:0] CELLS_A  = ADDR_W'(COLS * ROWS);

  logic [HC_W-1:0]   hCnt;
  logic [VC_W-1:0]   vCnt;
  logic [PH_W-1:0]   phase;
  logic [COL_W-1:0]  col;
  logic [SCAN_W-1:0] scan;
  logic [ADDR_W-1:0] rowBase;

  // raster counters: beam position of the fetch stage
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      hCnt    <= '0;
      vCnt    <= '0;
      phase   <= '0;
      col     <= '0;
      scan    <= '0;
      rowBase <= '0;
    end else if (hCnt == H_LAST) begin
      hCnt  <= '0;
      phase <= '0;
      col   <= '0;
      if (vCnt == V_LAST) begin
        vCnt    <= '0;
        scan    <= '0;
        rowBase <= '0;
      end else begin
        vCnt <= vCnt + 1'b1;
        if (vCnt < V_VIS_C) begin
          if (scan == SC_LAST) begin
            scan    <= '0;
            rowBase <= rowBase + COLS_A;
          end else begin
            scan <= scan + 1'b1;
          end
        end
      end
    end else begin
      hCnt <= hCnt + 1'b1;
      if (phase == PH_LAST) begin
        phase <= '0;
        col   <= col + 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  logic hAct, vAct;
  logic hsRaw, vsRaw, visRaw;

  always_comb begin
    hAct   = hCnt < H_VIS_C;
    vAct   = vCnt < V_VIS_C;
    hsRaw  = !((hCnt >= HS_START) && (hCnt < HS_END));
    vsRaw  = !((vCnt >= VS_START) && (vCnt < VS_END));
    visRaw = hAct && vAct;

    ctl.loadText  = vAct && hAct && (phase == '0);
    ctl.loadCode  = vAct && hAct && (phase == PH_LAST);
    ctl.loadFont  = vAct && (phase == '0) && (hCnt >= FONT_1ST) && (hCnt <= H_VIS_C);
    ctl.loadShift = vAct && (phase == PH_LAST) && (hCnt >= SH_FIRST) && (hCnt < SH_END);
    ctl.textIdx   = rowBase + ADDR_W'(col);
    ctl.scan      = scan;
  end

  // sync and blanking delayed by the fetch pipeline depth
  logic [LAT-1:0] hsDly, vsDly, visDly;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      hsDly  <= '1;
      vsDly  <= '1;
      visDly <= '0;
    end else begin
      hsDly  <= {hsDly[LAT-2:0], hsRaw};
      vsDly  <= {vsDly[LAT-2:0], vsRaw};
      visDly <= {visDly[LAT-2:0], visRaw};
    end
  end

  assign hsyncOut = hsDly[LAT-1];
  assign vsyncOut = vsDly[LAT-1];
  assign visOut   = visDly[LAT-1];

  // length of the current low stretch of hsync at the output
  logic [HC_W-1:0] hsLowCnt;
  always_ff @(posedge clk or posedge rst) begin
    if (rst)            hsLowCnt <= '0;
    else if (!hsyncOut) hsLowCnt <= hsLowCnt + 1'b1;
    else                hsLowCnt <= '0;
  end

  assert_hsync_width_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(hsyncOut) |-> (hsLowCnt == HS_WIDTH));

  assert_vsync_at_line_start_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(vsyncOut) |-> (hsyncOut && $past(hsyncOut)));

  assert_rowbase_end_R4: assert property (@(posedge clk) disable iff (rst)
    ((vCnt == V_VIS_C) && (hCnt == '0)) |-> (rowBase == CELLS_A));
endmodule

// File: rtl/disp_fetch_path.sv
`timescale 1ns/1ps
module disp_fetch_path
  import txt_disp_pkg::*;
#(
  parameter int CELL_W     = 8,
  parameter int CELL_H     = 12,
  parameter int CODE_W     = 8,
  parameter int TEXT_CELLS = 3200
) (
  input  logic              clk,
  input  logic              rst,
  input  fetchCtl_t         ctl,
  output logic [ADDR_W-1:0] textAddr,
  input  logic [CODE_W-1:0] textData,
  output logic [ADDR_W-1:0] fontAddr,
  input  logic [CELL_W-1:0] fontData,
  output logic              glyphBit
);
  localparam logic [ADDR_W-1:0] CELL_H_A = ADDR_W'(CELL_H);
  localparam logic [ADDR_W-1:0] CELLS_A  = ADDR_W'(TEXT_CELLS);

  logic [CODE_W-1:0] codeQ;
  logic [CELL_W-1:0] shiftQ;
  logic [ADDR_W-1:0] glyphBase;
  logic [ADDR_W-1:0] fontNext;

  always_comb begin
    glyphBase = ADDR_W'(codeQ) * CELL_H_A;
    fontNext  = glyphBase + ADDR_W'(ctl.scan);
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      textAddr <= '0;
      codeQ    <= '0;
      fontAddr <= '0;
      shiftQ   <= '0;
    end else begin
      if (ctl.loadText) textAddr <= ctl.textIdx;
      if (ctl.loadCode) codeQ    <= textData;
      if (ctl.loadFont) fontAddr <= fontNext;
      if (ctl.loadShift) shiftQ  <= fontData;
      else               shiftQ  <= {shiftQ[CELL_W-2:0], 1'b0};
    end
  end

  assign glyphBit = shiftQ[CELL_W-1];

  assert_text_hold_R7: assert property (@(posedge clk) disable iff (rst)
    ctl.loadCode |-> ($stable(textAddr) && (textAddr == $past(textAddr, 5))));

  assert_font_hold_R7: assert property (@(posedge clk) disable iff (rst)
    ctl.loadShift |-> ($stable(fontAddr) && (fontAddr == $past(fontAddr, 5))));

  assert_text_bound_R4: assert property (@(posedge clk) disable iff (rst)
    ctl.loadText |=> (textAddr < CELLS_A));
endmodule

// File: rtl/txt_disp_engine.sv
`timescale 1ns/1ps
module txt_disp_engine
  import txt_disp_pkg::*;
#(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  parameter int CELL_W = 8,
  parameter int CELL_H = 12,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] textAddr,
  input  logic [CODE_W-1:0] textData,
  output logic [ADDR_W-1:0] fontAddr,
  input  logic [CELL_W-1:0] fontData,
  output logic              pixel,
  output logic              hsync,
  output logic              vsync
);
  localparam int TEXT_CELLS = (H_VIS / CELL_W) * (V_VIS / CELL_H);

  fetchCtl_t ctl;
  logic      visDly;
  logic      glyphBit;

  disp_timing_ctl #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .CELL_W(CELL_W), .CELL_H(CELL_H)
  ) ctl_i (
    .clk(clk), .rst(rst), .ctl(ctl),
    .hsyncOut(hsync), .vsyncOut(vsync), .visOut(visDly)
  );

  disp_fetch_path #(
    .CELL_W(CELL_W), .CELL_H(CELL_H), .CODE_W(CODE_W), .TEXT_CELLS(TEXT_CELLS)
  ) path_i (
    .clk(clk), .rst(rst), .ctl(ctl),
    .textAddr(textAddr), .textData(textData),
    .fontAddr(fontAddr), .fontData(fontData),
    .glyphBit(glyphBit)
  );

  assign pixel = glyphBit & visDly;
endmodule

// File: tb/txt_disp_engine_tb_top.sv
`timescale 1ns/1ps
module txt_disp_engine_tb_top;
  localparam int CLK_PERIOD = 40;
  localparam int H_VIS = 64, H_FP = 8, H_SYNC = 8, H_BP = 8;
  localparam int V_VIS = 36, V_FP = 2, V_SYNC = 2, V_BP = 3;
  localparam int CELL_W = 8, CELL_H = 12;
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int COLS = H_VIS / CELL_W;
  localparam int ROWS = V_VIS / CELL_H;
  localparam int CELLS = COLS * ROWS;
  localparam int FONT_SZ = 256 * CELL_H;
  localparam int FRAME = H_TOT * V_TOT;
  localparam int WATCHDOG = 100000;
  localparam int MIN_HOLD = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [11:0] textAddr, fontAddr;
  logic [7:0]  textData, fontData;
  logic pixel, hsync, vsync;

  logic [7:0] textMem [CELLS];
  logic [7:0] fontMem [FONT_SZ];

  int checks = 0;
  int fails = 0;
  int maxAddr = 0;
  int minAddr = 4095;

  always #(CLK_PERIOD/2) clk = ~clk;

  txt_disp_engine #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .CELL_W(CELL_W), .CELL_H(CELL_H), .CODE_W(8)
  ) dut_i (
    .clk(clk), .rst(rst),
    .textAddr(textAddr), .textData(textData),
    .fontAddr(fontAddr), .fontData(fontData),
    .pixel(pixel), .hsync(hsync), .vsync(vsync)
  );

  // synchronous memories; data read under a young address comes back inverted
  int tAge = 0, fAge = 0;
  logic [11:0] tLast = '0, fLast = '0;
  always @(posedge clk) begin
    if (textAddr == tLast) tAge = (tAge < 100) ? tAge + 1 : tAge;
    else tAge = 1;
    tLast = textAddr;
    textData <= (tAge >= MIN_HOLD) ? textMem[textAddr % CELLS] : ~textMem[textAddr % CELLS];
    if (fontAddr == fLast) fAge = (fAge < 100) ? fAge + 1 : fAge;
    else fAge = 1;
    fLast = fontAddr;
    fontData <= (fAge >= MIN_HOLD) ? fontMem[fontAddr % FONT_SZ] : ~fontMem[fontAddr % FONT_SZ];
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      if (fails <= 20) $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expPix(input int x, input int y);
    logic [7:0] code, b;
    if (x >= H_VIS || y >= V_VIS) return 0;
    code = textMem[(y / CELL_H) * COLS + x / CELL_W];
    b = fontMem[int'(code) * CELL_H + y % CELL_H];
    return int'(b[CELL_W - 1 - (x % CELL_W)]);
  endfunction

  task automatic fillFont();
    for (int i = 0; i < FONT_SZ; i++) fontMem[i] = 8'($urandom);
    for (int s = 0; s < CELL_H; s++) begin
      fontMem[8'hA5 * CELL_H + s] = 8'h80;  // leftmost pixel only
      fontMem[8'h00 * CELL_H + s] = 8'h01;  // rightmost pixel only
    end
  endtask

  task automatic fillText(input int mode);
    for (int i = 0; i < CELLS; i++) begin
      case (mode)
        0: textMem[i] = 8'($urandom);
        1: textMem[i] = 8'(i * 37 + 5);
        default: textMem[i] = 8'($urandom);
      endcase
    end
    if (mode == 0) begin
      textMem[0] = 8'hA5;
      textMem[COLS - 1] = 8'h00;
      textMem[COLS] = 8'hA5;
    end else begin
      textMem[CELLS - 1] = 8'hFF;  // highest glyph address
      textMem[0] = 8'h00;
    end
  endtask

  task automatic resetCheck(input string when);
    check(hsync === 1'b1, {"R9 hsync ", when}, int'(hsync), 1);
    check(vsync === 1'b1, {"R9 vsync ", when}, int'(vsync), 1);
    check(pixel === 1'b0, {"R9 pixel ", when}, int'(pixel), 0);
    check(textAddr === 12'd0, {"R9 textAddr ", when}, int'(textAddr), 0);
    check(fontAddr === 12'd0, {"R9 fontAddr ", when}, int'(fontAddr), 0);
  endtask

  // lock to the vsync fall (line V_VIS+V_FP, position 0) and compare n cycles
  task automatic runCycles(input int n);
    int x, y, e;
    logic prevVs;
    prevVs = vsync;
    forever begin
      @(negedge clk);
      if (prevVs && !vsync) break;
      prevVs = vsync;
    end
    x = 0;
    y = V_VIS + V_FP;
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      e = ((x >= H_VIS + H_FP) && (x < H_VIS + H_FP + H_SYNC)) ? 0 : 1;
      check(hsync === 1'(e), "R1 hsync", int'(hsync), e);
      e = ((y >= V_VIS + V_FP) && (y < V_VIS + V_FP + V_SYNC)) ? 0 : 1;
      check(vsync === 1'(e), "R2 vsync", int'(vsync), e);
      e = expPix(x, y);
      if (x >= H_VIS || y >= V_VIS)
        check(pixel === 1'b0, "R3 blank pixel", int'(pixel), 0);
      else if (x < CELL_W)
        check(pixel === 1'(e), "R8 first column pixel", int'(pixel), e);
      else
        check(pixel === 1'(e), "R5 R6 R7 R10 glyph pixel", int'(pixel), e);
      check(int'(textAddr) < CELLS, "R4 text address bound", int'(textAddr), CELLS - 1);
      if (int'(textAddr) > maxAddr) maxAddr = int'(textAddr);
      if (int'(textAddr) < minAddr) minAddr = int'(textAddr);
      x++;
      if (x == H_TOT) begin
        x = 0;
        y++;
        if (y == V_TOT) y = 0;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    fillFont();
    fillText(0);
    repeat (3) @(negedge clk);
    resetCheck("at power-up");
    rst = 1'b0;

    runCycles(2 * FRAME);
    check(maxAddr == CELLS - 1, "R4 last cell address", maxAddr, CELLS - 1);
    check(minAddr == 0, "R4 first cell address", minAddr, 0);

    fillText(1);
    runCycles(FRAME);

    // asynchronous reset in the middle of a frame
    repeat (700) @(negedge clk);
    #(CLK_PERIOD/4);
    rst = 1'b1;
    #1;
    resetCheck("async mid-frame");
    repeat (4) @(negedge clk);
    resetCheck("held");
    rst = 1'b0;

    fillText(2);
    textMem[0] = 8'hA5;
    runCycles(FRAME);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule